// File: doc/BRIEF.md
# Digital I/O Register Bank

This block is the byte-addressed register bank of a general digital I/O card. A host reaches it through a simple byte-wide bus with an address, separate read and write strobes, write data and registered read data. Behind the bus it holds three bytes of output latches that drive 24 output lines. It samples 24 input-only lines. It also runs one 8-bit TTL port whose direction is set by a control bit: when that bit is set, the port drives its own latch onto the pins; when it is clear, the port only listens.

Several locations act differently on read and on write. The input locations can only be read. The status location at the top of the map returns the interrupt pin level when read, and any write to it resets the whole bank. A change-of-state enable byte is held here and handed to a separate detector. The bank also gives that detector the synchronized copies of every sampled line.

Top module: `dio_regbank`

## Requirements
- R1: Offsets 0, 1 and 2 are read/write latches. Byte k drives out_lines[8k+7:8k] from the clock edge that accepts the write, and reads back the value last written.
- R2: Offset 3 is the TTL output latch and can be read and written. While ttl_oe is 1, ttl_pin_out equals that latch; while ttl_oe is 0, ttl_pin_out is 0 and the pad is undriven.
- R3: Offset 12 is a read/write control byte and all 8 bits read back. Bit 1 of it is ttl_oe: 1 selects output mode and 0 selects input mode.
- R4: A read of offset 7 returns the synchronized levels on ttl_pin_in, in either direction mode. This is independent of the latch at offset 3.
- R5: Offsets 4, 5 and 6 return in_lines[7:0], [15:8] and [23:16] after a two-flop synchronizer. Writes to offsets 4 to 7 change no state.
- R6: Offset 13 and offsets 8 to 11 read as 0x00, and writes to them change no state.
- R7: Offset 14 is a read/write enable byte whose value appears on cos_en.
- R8: A read of offset 15 returns {7'b0, irq_pin} sampled with the read strobe. A write to offset 15 with any data clears offsets 0-3, 12 and 14 to zero at that edge.
- R9: After hardware reset, out_lines, cos_en, ttl_oe, ttl_pin_out and bus_rdata are all zero.
- R10: bus_rdata is loaded on the clock edge that samples bus_rd and holds between reads. A read and a write to the same offset in one cycle return the value from before the write.
- R11: sync_out carries {synchronized ttl_pin_in, synchronized in_lines} for the change-of-state detector, two edges after a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | 4 | Byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| out_lines | output | 24 | Output line drive |
| in_lines | input | 24 | Input-only line levels, asynchronous |
| ttl_pin_in | input | 8 | Pad levels of the TTL port |
| ttl_pin_out | output | 8 | TTL pad drive value |
| ttl_oe | output | 1 | TTL pad drive enable |
| cos_en | output | 8 | Change-of-state enable byte to the detector |
| irq_pin | input | 1 | Level of the interrupt output pin |
| sync_out | output | 32 | Synchronized TTL and input levels to the detector |

## Verification
A wrong latch or control bit appears on out_lines, ttl_pin_out or ttl_oe at the edge that takes the write, so no read is needed to see it. A wrong read-back path only shows in bus_rdata one edge after the read strobe. Synchronizer faults move the first change of bus_rdata or sync_out away from the second edge after a pin change. A soft reset that misses some state leaves a nonzero drive value or enable bit straight after the write to offset 15.

// File: rtl/dio_pkg.sv
package dio_pkg;
   // byte offsets of the bank; decoders compare them against the full address
   localparam int unsigned OFS_OUT_BASE = 0;
   localparam int unsigned OFS_TTL_OUT  = 3;
   localparam int unsigned OFS_IN_BASE  = 4;
   localparam int unsigned OFS_TTL_IN   = 7;
   localparam int unsigned OFS_CTL      = 12;
   localparam int unsigned OFS_RSVD     = 13;
   localparam int unsigned OFS_COSEN    = 14;
   localparam int unsigned OFS_SRST     = 15;
   localparam int unsigned MAX_BYTES    = 3;

   // write strobes for the single-byte registers
   typedef struct packed {
      logic ttl;
      logic ctl;
      logic cosen;
      logic srst;
   } wr_strb_t;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dio_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("dio_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= d;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dio_latch.sv
module dio_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr) begin
         q <= '0;
      end else if (we) begin
         q <= d;
      end
   end
endmodule

// File: rtl/dio_addr_dec.sv
module dio_addr_dec
   import dio_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int NB     = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic [NB-1:0]     wr_out,
   output wr_strb_t          wr_one
);
   for (genvar i = 0; i < NB; i++) begin : g_out
      assign wr_out[i] = wr && (addr == ADDR_W'(OFS_OUT_BASE + i));
   end

   assign wr_one.ttl   = wr && (addr == ADDR_W'(OFS_TTL_OUT));
   assign wr_one.ctl   = wr && (addr == ADDR_W'(OFS_CTL));
   assign wr_one.cosen = wr && (addr == ADDR_W'(OFS_COSEN));
   assign wr_one.srst  = wr && (addr == ADDR_W'(OFS_SRST));
endmodule

// File: rtl/dio_rd_mux.sv
module dio_rd_mux
   import dio_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int NB     = 3,
   parameter int DW     = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NB*DW-1:0]  out_q,
   input  logic [NB*DW-1:0]  in_s,
   input  logic [DW-1:0]     ttl_q,
   input  logic [DW-1:0]     ttl_s,
   input  logic [DW-1:0]     ctl_q,
   input  logic [DW-1:0]     cosen_q,
   input  logic              irq,
   output logic [DW-1:0]     data
);
   always_comb begin
      data = '0;
      for (int i = 0; i < NB; i++) begin
         if (addr == ADDR_W'(OFS_OUT_BASE + i)) data = out_q[i*DW +: DW];
         if (addr == ADDR_W'(OFS_IN_BASE + i))  data = in_s[i*DW +: DW];
      end
      if (addr == ADDR_W'(OFS_TTL_OUT)) data = ttl_q;
      if (addr == ADDR_W'(OFS_TTL_IN))  data = ttl_s;
      if (addr == ADDR_W'(OFS_CTL))     data = ctl_q;
      if (addr == ADDR_W'(OFS_COSEN))   data = cosen_q;
      if (addr == ADDR_W'(OFS_SRST))    data = {{(DW-1){1'b0}}, irq};
   end
endmodule

// File: rtl/dio_regbank.sv
module dio_regbank
   import dio_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DW          = 8,
   parameter int NB          = 3,
   parameter int SYNC_STAGES = 2,
   parameter int OE_BIT      = 1,
   localparam int LINES      = NB*DW,
   localparam int SYNC_W     = LINES + DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic [LINES-1:0]  out_lines,
   input  logic [LINES-1:0]  in_lines,
   input  logic [DW-1:0]     ttl_pin_in,
   output logic [DW-1:0]     ttl_pin_out,
   output logic              ttl_oe,
   output logic [DW-1:0]     cos_en,
   input  logic              irq_pin,
   output logic [SYNC_W-1:0] sync_out
);
   if (ADDR_W < 4) begin : g_bad_addr
      $error("dio_regbank: ADDR_W must cover 16 offsets");
   end
   if (NB < 1 || NB > MAX_BYTES) begin : g_bad_nb
      $error("dio_regbank: NB must be 1 to 3");
   end
   if (OE_BIT < 0 || OE_BIT >= DW) begin : g_bad_oe
      $error("dio_regbank: OE_BIT outside the data byte");
   end

   logic [NB-1:0]     wr_out;
   wr_strb_t          wr_one;
   logic              soft_clr;
   logic [LINES-1:0]  out_q;
   logic [DW-1:0]     ttl_q;
   logic [DW-1:0]     ctl_q;
   logic [DW-1:0]     cosen_q;
   logic [SYNC_W-1:0] sync_q;
   logic [DW-1:0]     rd_next;

   dio_addr_dec #(.ADDR_W(ADDR_W), .NB(NB)) u_dec (
      .addr   (bus_addr),
      .wr     (bus_wr),
      .wr_out (wr_out),
      .wr_one (wr_one)
   );

   assign soft_clr = wr_one.srst;

   for (genvar i = 0; i < NB; i++) begin : g_out_byte
      dio_latch #(.W(DW)) u_out (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (soft_clr),
         .we    (wr_out[i]),
         .d     (bus_wdata),
         .q     (out_q[i*DW +: DW])
      );
   end

   dio_latch #(.W(DW)) u_ttl (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .we(wr_one.ttl), .d(bus_wdata), .q(ttl_q)
   );

   dio_latch #(.W(DW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .we(wr_one.ctl), .d(bus_wdata), .q(ctl_q)
   );

   dio_latch #(.W(DW)) u_cosen (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .we(wr_one.cosen), .d(bus_wdata), .q(cosen_q)
   );

   dio_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ttl_pin_in, in_lines}),
      .q     (sync_q)
   );

   dio_rd_mux #(.ADDR_W(ADDR_W), .NB(NB), .DW(DW)) u_mux (
      .addr    (bus_addr),
      .out_q   (out_q),
      .in_s    (sync_q[LINES-1:0]),
      .ttl_q   (ttl_q),
      .ttl_s   (sync_q[SYNC_W-1:LINES]),
      .ctl_q   (ctl_q),
      .cosen_q (cosen_q),
      .irq     (irq_pin),
      .data    (rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_next;
      end
   end

   assign out_lines   = out_q;
   assign ttl_oe      = ctl_q[OE_BIT];
   assign ttl_pin_out = ttl_oe ? ttl_q : '0;
   assign cos_en      = cosen_q;
   assign sync_out    = sync_q;
endmodule

// File: rtl/dio_regbank_chk.sv
module dio_regbank_chk
   import dio_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DW     = 8,
   parameter int NB     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DW-1:0]     bus_wdata,
   input logic [DW-1:0]     bus_rdata,
   input logic [NB*DW-1:0]  out_lines,
   input logic [DW-1:0]     ttl_pin_out,
   input logic              ttl_oe,
   input logic [DW-1:0]     cos_en,
   input logic              irq_pin
);
   p_out0_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(OFS_OUT_BASE) |=> out_lines[DW-1:0] == $past(bus_wdata));

   p_ttl_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(OFS_TTL_OUT) && ttl_oe |=> ttl_pin_out == $past(bus_wdata));

   p_oe_from_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(OFS_CTL) |=> ttl_oe == $past(bus_wdata[1]));

   p_ro_no_effect_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr >= ADDR_W'(OFS_IN_BASE) && bus_addr <= ADDR_W'(OFS_TTL_IN)
      |=> $stable(out_lines) && $stable(cos_en) && $stable(ttl_oe));

   p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == ADDR_W'(OFS_RSVD) |=> bus_rdata == '0);

   p_cosen_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(OFS_COSEN) |=> cos_en == $past(bus_wdata));

   p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == ADDR_W'(OFS_SRST) |=> out_lines == '0 && cos_en == '0 && !ttl_oe);

   p_irq_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && bus_addr == ADDR_W'(OFS_SRST) |=> bus_rdata == {{(DW-1){1'b0}}, $past(irq_pin)});

   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

bind dio_regbank dio_regbank_chk #(.ADDR_W(ADDR_W), .DW(DW), .NB(NB)) u_chk (.*);

// File: tb/tb_dio_regbank.sv
module tb_dio_regbank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [23:0] out_lines;
   logic [23:0] in_lines = '0;
   logic [7:0]  ttl_pin_in;
   logic [7:0]  ttl_pin_out;
   logic        ttl_oe;
   logic [7:0]  cos_en;
   logic        irq_pin = 1'b0;
   logic [31:0] sync_out;
   logic [7:0]  ttl_ext = '0;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // pad model: the port drives its own pins in output mode
   assign ttl_pin_in = ttl_oe ? ttl_pin_out : ttl_ext;

   dio_regbank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .out_lines(out_lines), .in_lines(in_lines), .ttl_pin_in(ttl_pin_in),
      .ttl_pin_out(ttl_pin_out), .ttl_oe(ttl_oe), .cos_en(cos_en),
      .irq_pin(irq_pin), .sync_out(sync_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic t_reset();
      chk("R9 out_lines", 32'(out_lines), 0);
      chk("R9 ttl_oe", 32'(ttl_oe), 0);
      chk("R9 ttl_pin_out", 32'(ttl_pin_out), 0);
      chk("R9 cos_en", 32'(cos_en), 0);
      chk("R9 rdata", 32'(bus_rdata), 0);
   endtask

   task automatic t_out_latch();
      logic [7:0] v;
      wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'h81);
      chk("R1 out_lines", 32'(out_lines), 32'h813CA5);
      rd(1, v); chk("R1 readback 1", 32'(v), 32'h3C);
      rd(2, v); chk("R1 readback 2", 32'(v), 32'h81);
   endtask

   task automatic t_inputs();
      logic [7:0] v;
      @(negedge clk); in_lines = 24'h123456;
      @(negedge clk);
      chk("R11 one edge not yet", sync_out[23:0], 24'h0);
      @(negedge clk);
      chk("R11 sync_out", 32'(sync_out[23:0]), 32'h123456);
      rd(4, v); chk("R5 in byte0", 32'(v), 32'h56);
      rd(5, v); chk("R5 in byte1", 32'(v), 32'h34);
      rd(6, v); chk("R5 in byte2", 32'(v), 32'h12);
      wr(4, 8'hFF); wr(7, 8'hFF);
      rd(4, v); chk("R5 write ignored", 32'(v), 32'h56);
      chk("R5 outputs untouched", 32'(out_lines), 32'h813CA5);
      chk("R5 ttl_oe untouched", 32'(ttl_oe), 0);
   endtask

   task automatic t_ttl();
      logic [7:0] v;
      @(negedge clk); ttl_ext = 8'h5A;
      repeat (3) @(negedge clk);
      rd(7, v); chk("R4 pins in input mode", 32'(v), 32'h5A);
      wr(3, 8'hC3);
      chk("R2 no drive in input mode", 32'(ttl_pin_out), 0);
      rd(3, v); chk("R2 latch readback", 32'(v), 32'hC3);
      rd(7, v); chk("R4 pins not latch", 32'(v), 32'h5A);
      wr(12, 8'h02);
      chk("R3 oe set", 32'(ttl_oe), 1);
      chk("R2 drive latch", 32'(ttl_pin_out), 32'hC3);
      repeat (3) @(negedge clk);
      rd(7, v); chk("R4 pins in output mode", 32'(v), 32'hC3);
      chk("R11 ttl sync", 32'(sync_out[31:24]), 32'hC3);
      wr(12, 8'hFD);
      chk("R3 oe clear", 32'(ttl_oe), 0);
      rd(12, v); chk("R3 ctl readback", 32'(v), 32'hFD);
   endtask

   task automatic t_reserved();
      logic [7:0] v;
      wr(13, 8'hFF); wr(9, 8'hFF);
      rd(13, v); chk("R6 offset 13", 32'(v), 0);
      rd(8, v);  chk("R6 offset 8", 32'(v), 0);
      rd(11, v); chk("R6 offset 11", 32'(v), 0);
      chk("R6 outputs untouched", 32'(out_lines), 32'h813CA5);
   endtask

   task automatic t_cosen();
      logic [7:0] v;
      wr(14, 8'h9F);
      chk("R7 cos_en", 32'(cos_en), 32'h9F);
      rd(14, v); chk("R7 readback", 32'(v), 32'h9F);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      irq_pin = 1'b1;
      rd(15, v); chk("R8 irq high", 32'(v), 1);
      irq_pin = 1'b0;
      rd(15, v); chk("R8 irq low", 32'(v), 0);
   endtask

   task automatic t_rd_timing();
      @(negedge clk);
      bus_addr = 0; bus_wdata = 8'h22; bus_wr = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      chk("R10 read before write", 32'(bus_rdata), 32'hA5);
      chk("R10 write taken", 32'(out_lines[7:0]), 32'h22);
      wr(14, 8'h01);
      chk("R10 rdata holds", 32'(bus_rdata), 32'hA5);
   endtask

   task automatic t_soft_reset();
      logic [7:0] v;
      wr(12, 8'h02);
      wr(15, 8'h00);
      chk("R8 srst out_lines", 32'(out_lines), 0);
      chk("R8 srst oe", 32'(ttl_oe), 0);
      chk("R8 srst cos_en", 32'(cos_en), 0);
      rd(3, v);  chk("R8 srst ttl latch", 32'(v), 0);
      rd(12, v); chk("R8 srst ctl", 32'(v), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_out_latch();
      t_inputs();
      t_ttl();
      t_reserved();
      t_cosen();
      t_irq();
      t_rd_timing();
      t_soft_reset();
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule